// File: doc/BRIEF.md
# Five-Stage Integer Pipeline with Address-Dependent Memory Latency

`lat_pipe5` is a small in-order integer core. Each instruction passes through fetch, decode, execute, memory and writeback stages. It runs five operations: load, store, add with an immediate, AND with an immediate, and add of two registers. Results reach later instructions through forwarding paths. The register file is only the fallback when no forwarding path applies. A load whose result is needed by the very next instruction costs exactly one bubble.

Memory timing depends only on the address. An access that falls inside a fixed window completes in one cycle. Any other access takes `MISS_LAT` cycles. This applies to both instruction fetches and data accesses. While such an access is outstanding, a global freeze holds the front four stages and sends empty slots into writeback.

Two debug counters report the number of completed instructions and the number of elapsed cycles. With these, a program's total run time can be measured with and without slow accesses.

Top module: `lat_pipe5`

## Requirements
- R1: On a synchronous reset, the fetch address returns to `RESET_PC` (0x0000_1000), all registers are cleared, both counters read zero, and no store is issued. The first fetch after reset happens in cycle 1.
- R2: The instruction word is split into fields as follows: opcode in [31:28], destination register in [27:25], first source register in [24:22], second source register in [21:19], and a signed immediate in [15:0]. The opcodes are: 1 = load, 2 = store, 3 = add-immediate, 4 = AND-immediate (immediate sign-extended), 5 = three-register add. Loads and stores use the effective address first-source + immediate. A store writes the second source to that address. The fetch address advances by 4 for each instruction accepted.
- R3: A source register is taken from the newest older producer still in flight. An ALU result in the memory stage wins over a result in writeback for the same register. Store data is forwarded in the same way as address operands. Register 0 is an ordinary writable register.
- R4: A load followed directly by an instruction that reads the loaded register causes exactly one bubble. The loaded value then reaches that instruction from writeback.
- R5: An access whose address A satisfies 0x0000_1000 <= A <= 0x0000_4000 takes one cycle. Any other fetch or data address takes `MISS_LAT` (3) cycles, which means `MISS_LAT`-1 extra freeze cycles.
- R6: During a freeze, the fetch, decode, execute and memory stages hold their contents. Each freeze cycle places an empty slot in writeback. A store whose address is outside the window writes memory once, in its last cycle.
- R7: `retired_count` rises by one for each load, store or ALU instruction that leaves writeback. Opcodes 0 and 6 to 15 change no register, no memory and no counter.
- R8: `cycle_count` rises by one on every clock edge outside reset.
- R9: For fetches inside the window, instruction i (counted from 0) completes in cycle i+5, plus one cycle for each load-use bubble at or before it, plus two cycles for each slow data access at or before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | XLEN | Fetch address |
| imem_rdata | input | 32 | Instruction word for `imem_addr`, same cycle |
| dmem_addr | output | XLEN | Data address of the memory-stage access |
| dmem_rd_en | output | 1 | Memory stage holds a load |
| dmem_wr_en | output | 1 | Store write strobe (one cycle per store) |
| dmem_wdata | output | XLEN | Store data |
| dmem_rdata | input | XLEN | Load data for `dmem_addr`, same cycle |
| retired_count | output | CNT_W | Completed instructions since reset |
| cycle_count | output | CNT_W | Clock edges since reset |

## Verification
Some properties are checked by assertions on every cycle:
- a load never sits in the memory stage while its direct consumer is in execute;
- a freeze keeps both memory addresses and the store data stable, and leaves writeback empty on the next cycle;
- a slow store is always preceded by a frozen cycle;
- the two counters step as specified.

Other behaviour can only be shown by the bench scenarios, which it compares every clock against an instruction-level model with timing arithmetic:
- forwarding priority between the memory stage and writeback;
- the edges of the address window;
- a load that is both slow and feeding its direct consumer;
- runs of slow fetches;
- total cycle counts.

// File: rtl/lat_pipe5.sv
module lat_pipe5 #(
  parameter int               XLEN     = 32,
  parameter int               NREG     = 8,
  parameter int               CNT_W    = 32,
  parameter int               MISS_LAT = 3,
  parameter logic [XLEN-1:0]  RESET_PC = 32'h0000_1000,
  parameter logic [XLEN-1:0]  WIN_LO   = 32'h0000_1000,
  parameter logic [XLEN-1:0]  WIN_HI   = 32'h0000_4000
) (
  input  logic             clk,
  input  logic             rst,
  output logic [XLEN-1:0]  imem_addr,
  input  logic [31:0]      imem_rdata,
  output logic [XLEN-1:0]  dmem_addr,
  output logic             dmem_rd_en,
  output logic             dmem_wr_en,
  output logic [XLEN-1:0]  dmem_wdata,
  input  logic [XLEN-1:0]  dmem_rdata,
  output logic [CNT_W-1:0] retired_count,
  output logic [CNT_W-1:0] cycle_count
);
  localparam int RW    = $clog2(NREG);
  localparam int WW    = $clog2(MISS_LAT + 1);
  localparam int F_RD  = 27;
  localparam int F_RS1 = 27 - RW;
  localparam int F_RS2 = 27 - 2 * RW;
  localparam logic [3:0] OP_LD = 4'd1, OP_ST = 4'd2, OP_ADDI = 4'd3,
                         OP_ANDI = 4'd4, OP_ADD = 4'd5;
  localparam logic [WW-1:0] WLAST = WW'(MISS_LAT - 1);

  function automatic logic in_win(input logic [XLEN-1:0] a);
    return (a >= WIN_LO) && (a <= WIN_HI);
  endfunction
  function automatic logic is_real(input logic [3:0] op);
    return (op >= OP_LD) && (op <= OP_ADD);
  endfunction
  function automatic logic wr_rd(input logic [3:0] op);
    return (op == OP_LD) || (op == OP_ADDI) || (op == OP_ANDI) || (op == OP_ADD);
  endfunction
  function automatic logic src2(input logic [3:0] op);
    return (op == OP_ST) || (op == OP_ADD);
  endfunction

  logic [XLEN-1:0] pc;
  logic            d_v;
  logic [31:0]     d_ir;
  logic            e_v;
  logic [3:0]      e_op;
  logic [RW-1:0]   e_rd, e_rs1, e_rs2;
  logic [XLEN-1:0] e_imm;
  logic            m_v;
  logic [3:0]      m_op;
  logic [RW-1:0]   m_rd;
  logic [XLEN-1:0] m_res, m_sd;
  logic            w_v, w_wr;
  logic [RW-1:0]   w_rd;
  logic [XLEN-1:0] w_val;
  logic [XLEN-1:0] rf [NREG];
  logic [WW-1:0]   wcnt;
  logic [CNT_W-1:0] cyc, ret;

  logic [3:0]      d_op;
  logic [RW-1:0]   d_rs1, d_rs2;
  logic            interlock, slow_fetch, slow_data, freeze;
  logic [XLEN-1:0] opa, opb, alu;

  assign d_op  = d_ir[31:28];
  assign d_rs1 = d_ir[F_RS1 -: RW];
  assign d_rs2 = d_ir[F_RS2 -: RW];

  assign interlock = d_v && e_v && (e_op == OP_LD) &&
                     ((d_rs1 == e_rd) || (src2(d_op) && d_rs2 == e_rd));

  assign slow_fetch = !in_win(pc);
  assign slow_data  = m_v && (m_op == OP_LD || m_op == OP_ST) && !in_win(m_res);
  assign freeze     = (slow_fetch || slow_data) && (wcnt != WLAST);

  always_comb begin
    opa = rf[e_rs1];
    opb = rf[e_rs2];
    if (w_v && w_wr && w_rd == e_rs1) opa = w_val;
    if (w_v && w_wr && w_rd == e_rs2) opb = w_val;
    if (m_v && m_op != OP_LD && wr_rd(m_op) && m_rd == e_rs1) opa = m_res;
    if (m_v && m_op != OP_LD && wr_rd(m_op) && m_rd == e_rs2) opb = m_res;
    case (e_op)
      OP_ANDI: alu = opa & e_imm;
      OP_ADD:  alu = opa + opb;
      default: alu = opa + e_imm;
    endcase
  end

  assign imem_addr     = pc;
  assign dmem_addr     = m_res;
  assign dmem_wdata    = m_sd;
  assign dmem_rd_en    = m_v && (m_op == OP_LD);
  assign dmem_wr_en    = m_v && (m_op == OP_ST) && !freeze;
  assign retired_count = ret;
  assign cycle_count   = cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= RESET_PC;
      d_v  <= 1'b0;
      e_v  <= 1'b0;
      m_v  <= 1'b0;
      w_v  <= 1'b0;
      wcnt <= '0;
      cyc  <= '0;
      ret  <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      cyc  <= cyc + CNT_W'(1);
      if (w_v) ret <= ret + CNT_W'(1);
      if (w_v && w_wr) rf[w_rd] <= w_val;
      wcnt <= freeze ? wcnt + WW'(1) : '0;
      if (freeze) begin
        w_v <= 1'b0;
      end else begin
        w_v   <= m_v;
        w_wr  <= wr_rd(m_op);
        w_rd  <= m_rd;
        w_val <= (m_op == OP_LD) ? dmem_rdata : m_res;
        m_v   <= e_v;
        m_op  <= e_op;
        m_rd  <= e_rd;
        m_res <= alu;
        m_sd  <= opb;
        if (interlock) begin
          e_v <= 1'b0;
        end else begin
          e_v   <= d_v;
          e_op  <= d_op;
          e_rd  <= d_ir[F_RD -: RW];
          e_rs1 <= d_rs1;
          e_rs2 <= d_rs2;
          e_imm <= {{(XLEN-16){d_ir[15]}}, d_ir[15:0]};
          d_v   <= is_real(imem_rdata[31:28]);
          d_ir  <= imem_rdata;
          pc    <= pc + XLEN'(4);
        end
      end
    end
  end

  assert_fwd_safe_R4: assert property (@(posedge clk) disable iff (rst)
    !(m_v && m_op == OP_LD && e_v &&
      ((e_rs1 == m_rd) || (src2(e_op) && e_rs2 == m_rd))));

  assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (rst)
    freeze |=> ($stable(imem_addr) && $stable(dmem_addr) && $stable(dmem_wdata)));

  assert_wb_bubble_R6: assert property (@(posedge clk) disable iff (rst)
    freeze |=> !w_v);

  assert_cycle_step_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cycle_count == $past(cycle_count) + CNT_W'(1)));

  assert_retire_step_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (retired_count == $past(retired_count) ||
              retired_count == $past(retired_count) + CNT_W'(1)));

  generate
    if (MISS_LAT > 1) begin : g_slow_chk
      assert_slow_store_R5: assert property (@(posedge clk) disable iff (rst)
        (dmem_wr_en && !in_win(dmem_addr)) |-> $past(freeze));
    end
  endgenerate
endmodule

// File: tb/lat_pipe5_bench.sv
`timescale 1ns/1ps
module lat_pipe5_bench;
  localparam logic [3:0] NOP = 4'd0, LD = 4'd1, ST = 4'd2, ADDI = 4'd3, ANDI = 4'd4, ADD = 4'd5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [31:0] ia, ird, da, dwd, drd, ret, cyc;
  logic        dre, dwe;
  logic [31:0] ib, irb, dab, dwdb, retb, cycb;
  logic        dreb, dweb;

  logic [31:0] prog [32];
  logic [31:0] progb [4];
  logic [31:0] dm [64];
  logic [31:0] mdm [64];
  int          rexp [32];
  int          plen, total_cyc, b_stores;
  logic [31:0] sq_a[$], sq_d[$];
  int          checks = 0, errors = 0;

  logic [31:0] ioff, ioffb;
  assign ioff  = ia - 32'h0000_1000;
  assign ird   = (ioff[31:7] == 25'd0) ? prog[ioff[6:2]] : 32'h0;
  assign ioffb = ib - 32'h0000_3FF8;
  assign irb   = (ioffb[31:4] == 28'd0) ? progb[ioffb[3:2]] : 32'h0;
  assign drd   = dm[da[7:2]];

  lat_pipe5 u_lat_pipe5 (
    .clk(clk), .rst(rst), .imem_addr(ia), .imem_rdata(ird),
    .dmem_addr(da), .dmem_rd_en(dre), .dmem_wr_en(dwe), .dmem_wdata(dwd),
    .dmem_rdata(drd), .retired_count(ret), .cycle_count(cyc));

  lat_pipe5 #(.RESET_PC(32'h0000_3FF8)) u_lat_pipe5_fm (
    .clk(clk), .rst(rst), .imem_addr(ib), .imem_rdata(irb),
    .dmem_addr(dab), .dmem_rd_en(dreb), .dmem_wr_en(dweb), .dmem_wdata(dwdb),
    .dmem_rdata(32'h0), .retired_count(retb), .cycle_count(cycb));

  function automatic logic [31:0] enc(logic [3:0] op, int rd, int s1, int s2, logic [15:0] imm);
    return {op, 3'(rd), 3'(s1), 3'(s2), 3'b000, imm};
  endfunction

  function automatic logic win(logic [31:0] a);
    return (a >= 32'h0000_1000) && (a <= 32'h0000_4000);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int due(int c);
    int n = 0;
    for (int i = 0; i < plen; i++) if (rexp[i] >= 0 && rexp[i] <= c) n++;
    return n;
  endfunction

  function automatic int due_b(int c);
    int n = 0;
    for (int i = 0; i < 4; i++) if (3 * i + 7 <= c) n++;
    return n;
  endfunction

  task automatic build_model();
    logic [31:0] r [8];
    logic [31:0] ins, imm, ea;
    logic [3:0]  op;
    logic [2:0]  rd, s1, s2, prev_rd;
    logic        prev_ld, rl;
    int          extra;
    extra = 0; prev_ld = 1'b0; prev_rd = 3'd0;
    for (int k = 0; k < 8; k++) r[k] = 32'h0;
    sq_a.delete(); sq_d.delete();
    for (int i = 0; i < plen; i++) begin
      ins = prog[i]; op = ins[31:28]; rd = ins[27:25]; s1 = ins[24:22]; s2 = ins[21:19];
      imm = {{16{ins[15]}}, ins[15:0]};
      rl = (op >= LD) && (op <= ADD);
      if (prev_ld && rl && (s1 == prev_rd || ((op == ST || op == ADD) && s2 == prev_rd)))
        extra++;
      ea = r[s1] + imm;
      case (op)
        LD:   begin if (!win(ea)) extra += 2; r[rd] = mdm[ea[7:2]]; end
        ST:   begin if (!win(ea)) extra += 2; mdm[ea[7:2]] = r[s2];
                    sq_a.push_back(ea); sq_d.push_back(r[s2]); end
        ADDI: r[rd] = r[s1] + imm;
        ANDI: r[rd] = r[s1] & imm;
        ADD:  r[rd] = r[s1] + r[s2];
        default: ;
      endcase
      rexp[i] = rl ? i + 5 + extra : -1;
      prev_ld = (op == LD);
      prev_rd = rd;
    end
    total_cyc = plen + 4 + extra;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = 32'h0;
  endtask

  task automatic run(string name);
    int c, last;
    for (int k = 0; k < 64; k++) begin
      dm[k]  = 32'h3000_0000 + 32'(k) * 32'h0001_0011;
      mdm[k] = dm[k];
    end
    build_model();
    b_stores = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({name, " R1 reset fetch address"}, ia, 32'h0000_1000);
    chk({name, " R1 reset retired"}, ret, 32'h0);
    chk({name, " R1 reset cycles"}, cyc, 32'h0);
    chk({name, " R1 reset no store"}, {31'h0, dwe}, 32'h0);
    rst = 1'b0;
    last = (total_cyc > 20 ? total_cyc : 20) + 6;
    for (c = 1; c <= last; c++) begin
      @(negedge clk);
      chk({name, " R8 cycle count"}, cyc, 32'(c));
      chk({name, " R9 R7 retired vs model"}, ret, 32'(due(c)));
      chk({name, " R5 R9 slow-fetch retired"}, retb, 32'(due_b(c)));
      if (dwe) begin
        if (sq_a.size() == 0) begin
          checks++; errors++;
          $display("FAIL %s R6 extra store actual %h expected none", name, da);
        end else begin
          chk({name, " R2 R3 store address"}, da, sq_a.pop_front());
          chk({name, " R3 R4 store data"}, dwd, sq_d.pop_front());
        end
        dm[da[7:2]] = dwd;
      end
      if (dweb) begin
        b_stores++;
        chk({name, " R5 slow-fetch store address"}, dab, 32'h0000_2004);
        chk({name, " R5 slow-fetch store data"}, dwdb, 32'd17);
      end
    end
    chk({name, " R6 all stores seen once"}, 32'(sq_a.size()), 32'h0);
    chk({name, " R5 slow-fetch store count"}, 32'(b_stores), 32'd1);
    chk({name, " R9 total cycles"}, 32'(rexp[plen-1]), 32'(total_cyc));
  endtask

  initial begin
    progb[0] = enc(ADDI, 1, 7, 0, 16'd7);
    progb[1] = enc(ADDI, 2, 1, 0, 16'd3);
    progb[2] = enc(ADD,  3, 1, 2, 16'd0);
    progb[3] = enc(ST,   0, 7, 3, 16'h2004);

    clear_prog();
    prog[0] = enc(ADDI, 0, 7, 0, 16'h2000);
    prog[1] = enc(ADDI, 4, 7, 0, 16'h5000);
    prog[2] = enc(LD,   1, 0, 0, 16'h0000);
    prog[3] = enc(ADDI, 2, 1, 0, 16'h0005);
    prog[4] = enc(ANDI, 3, 2, 0, 16'h0015);
    prog[5] = enc(ST,   0, 4, 3, 16'h0004);
    prog[6] = enc(ADD,  5, 2, 3, 16'h0000);
    prog[7] = enc(ST,   0, 0, 5, 16'h0008);
    plen = 8;
    run("chain");

    clear_prog();
    prog[0]  = enc(ADDI, 1, 7, 0, 16'd5);
    prog[1]  = enc(ADDI, 1, 1, 0, 16'd9);
    prog[2]  = enc(ADD,  2, 1, 1, 16'd0);
    prog[3]  = enc(ADDI, 0, 7, 0, 16'h3000);
    prog[4]  = enc(ST,   0, 0, 2, 16'h0000);
    prog[5]  = enc(LD,   3, 0, 0, 16'h0000);
    prog[6]  = enc(ST,   0, 0, 3, 16'h0004);
    prog[7]  = enc(NOP,  0, 0, 0, 16'h0000);
    prog[8]  = enc(4'd9, 3, 3, 0, 16'h0055);
    prog[9]  = enc(ST,   0, 0, 3, 16'h0008);
    prog[10] = enc(ADD,  0, 0, 0, 16'h0000);
    prog[11] = enc(ST,   0, 7, 0, 16'h000C);
    plen = 12;
    run("priority");

    clear_prog();
    prog[0] = enc(ADDI, 6, 7, 0, 16'h0FFC);
    prog[1] = enc(ST,   0, 6, 6, 16'h0000);
    prog[2] = enc(ST,   0, 6, 6, 16'h0004);
    prog[3] = enc(ADDI, 5, 7, 0, 16'h4000);
    prog[4] = enc(ST,   0, 5, 5, 16'h0000);
    prog[5] = enc(ST,   0, 5, 5, 16'h0004);
    prog[6] = enc(LD,   1, 5, 0, 16'hFFFC);
    prog[7] = enc(LD,   2, 5, 0, 16'h0004);
    prog[8] = enc(ADD,  3, 2, 1, 16'h0000);
    prog[9] = enc(ST,   0, 7, 3, 16'h0008);
    plen = 10;
    run("window");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule